// File: doc/BRIEF.md
# Divide-by-three clock generator

This block turns one fast reference clock into two slower, phase-locked clocks. The processor clock runs at one third of the reference rate. It is high for one reference period and low for the next two. The peripheral clock runs at half the processor-clock rate with an even duty cycle, and it changes state only where the processor clock falls. All state sits on the reference rising edge, so both outputs are clean registered levels.

A level-sensitive hold input makes several generators run in step. While the hold is seen, the divider is parked with both clocks high. The first reference rising edge after the hold is removed starts a fresh cycle in every instance at once. If the hold comes from an unrelated clock domain, a build option passes it through a rising-edge stage and then a falling-edge stage before the divider sees it. A source-select input records whether the crystal path or the external path is in use. It is reported as a status bit and has no effect on the divided clocks.

Top module: `div3_clock_gen`

## Requirements
- R1: While `rst_n` is low at a reference rising edge, the next output state has `cpu_clk` = 1, `per_clk` = 1 and `src_is_ext` = 0.
- R2: In free run, `cpu_clk` repeats with a period of three reference cycles. It is high for exactly one of the three and low for the other two.
- R3: In free run, `per_clk` repeats with a period of six reference cycles. It is high for three and low for three. It changes only on the reference edge where `cpu_clk` goes from 1 to 0.
- R4: When the divider sees the hold at a reference rising edge, both `cpu_clk` and `per_clk` are 1 after that edge, and they stay 1 for as long as the hold lasts.
- R5: At the first rising edge where the hold is no longer seen, `cpu_clk` falls to 0 and `per_clk` falls to 0. `cpu_clk` next rises on the third edge after release, and the waveform of R2 and R3 then continues.
- R6: With `RESYNC` = 1, the hold is captured on a reference rising edge and then on the following falling edge. The divider therefore responds to each change of `sync_req` exactly one reference cycle later than with `RESYNC` = 0.
- R7: `src_is_ext` equals the value `sel_ext` had at the previous rising edge (0 = crystal path, 1 = external path). `sel_ext` has no effect on `cpu_clk` or `per_clk`.
- R8: Two instances that are released by the same hold produce identical `cpu_clk` and `per_clk` waveforms from then on, whatever their phases were before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock; every register uses its edges |
| rst_n | input | 1 | Synchronous active-low local reset |
| sync_req | input | 1 | Level-sensitive hold/restart request for the divider |
| sel_ext | input | 1 | Source select: 0 crystal path, 1 external path |
| cpu_clk | output | 1 | Reference divided by three, one-third duty |
| per_clk | output | 1 | `cpu_clk` divided by two, 50% duty |
| src_is_ext | output | 1 | Registered copy of the source select |

## Verification
A wrong divider count shows at the ports within one reference cycle. `cpu_clk` would then rise early or late, so a free-running comparison against an edge counter catches it on the next edge. A wrong peripheral phase bit only shows at the next `cpu_clk` fall, which comes at most three cycles later. Release skew between instances, or an extra or missing stage on the resynchronised hold, shows up as a one-cycle offset between waveforms on the first edge after the hold is removed.

// File: rtl/div3_clock_gen.sv
module div3_clock_gen #(
  parameter bit RESYNC = 1'b0
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic sync_req,
  input  logic sel_ext,
  output logic cpu_clk,
  output logic per_clk,
  output logic src_is_ext
);

  localparam logic [1:0] LAST = 2'd2;

  logic [1:0] phase;
  logic       per_q;
  logic       src_q;
  logic       hold_eff;

  generate
    if (RESYNC) begin : g_resync
      logic s_rise;
      logic s_fall;
      always_ff @(posedge ref_clk) s_rise <= sync_req;
      always_ff @(negedge ref_clk) s_fall <= s_rise;
      assign hold_eff = s_fall;

      // R6
      resync_lag_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        hold_eff == $past(sync_req));
    end else begin : g_direct
      assign hold_eff = sync_req;
    end
  endgenerate

  wire restart = !rst_n || hold_eff;

  always_ff @(posedge ref_clk) begin
    if (restart) begin
      phase <= 2'd0;
      per_q <= 1'b1;
    end else begin
      phase <= (phase == LAST) ? 2'd0 : phase + 2'd1;
      if (phase == 2'd0) per_q <= ~per_q;
    end
    src_q <= rst_n ? sel_ext : 1'b0;
  end

  assign cpu_clk    = (phase == 2'd0);
  assign per_clk    = per_q;
  assign src_is_ext = src_q;

  // R1
  reset_state_chk: assert property (@(posedge ref_clk)
    !rst_n |=> (cpu_clk && per_clk && !src_is_ext));

  // R2
  high_one_cycle_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cpu_clk && !hold_eff) |=> !cpu_clk);

  // R2
  low_two_cycles_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!cpu_clk && !$past(cpu_clk) && !hold_eff) |=> cpu_clk);

  // R3
  per_still_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!cpu_clk && !hold_eff) |=> $stable(per_clk));

  // R3
  per_flip_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cpu_clk && !hold_eff) |=> (per_clk != $past(per_clk)));

  // R4
  hold_high_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    hold_eff |=> (cpu_clk && per_clk));

  // R7
  src_follow_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    1'b1 |=> (src_is_ext == $past(sel_ext)));

endmodule

// File: tb/sim_div3_clock_gen.sv
module sim_div3_clock_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0, sync_a = 1'b0, sync_b = 1'b0, sel = 1'b0;
  logic c0, p0, s0, c1, p1, s1, c2, p2, s2;

  always #10 clk = ~clk;

  div3_clock_gen u0 (.ref_clk(clk), .rst_n(rst_n), .sync_req(sync_a), .sel_ext(sel),
                     .cpu_clk(c0), .per_clk(p0), .src_is_ext(s0));
  div3_clock_gen u1 (.ref_clk(clk), .rst_n(rst_n), .sync_req(sync_b), .sel_ext(sel),
                     .cpu_clk(c1), .per_clk(p1), .src_is_ext(s1));
  div3_clock_gen #(.RESYNC(1'b1)) u2 (.ref_clk(clk), .rst_n(rst_n), .sync_req(sync_a),
                     .sel_ext(sel), .cpu_clk(c2), .per_clk(p2), .src_is_ext(s2));

  int n_chk = 0, n_bad = 0;
  bit cmp_en = 0, same_en = 0, done = 0;
  int k0 = 0, k1 = 0, k2 = 0;
  bit d2 = 1'b1, h2, exp_src = 1'b0;

  function automatic bit exp_cpu(int k); return (k % 3) == 0; endfunction
  function automatic bit exp_per(int k); return (((k + 2) / 3) % 2) == 0; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural edge-count model
  always @(posedge clk) begin
    h2 = d2;
    d2 = sync_a;
    k0 = (!rst_n || sync_a) ? 0 : k0 + 1;
    k1 = (!rst_n || sync_b) ? 0 : k1 + 1;
    k2 = (!rst_n || h2) ? 0 : k2 + 1;
    exp_src = rst_n ? sel : 1'b0;
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(c0 == exp_cpu(k0), "R2/R4/R5 u0 cpu_clk", c0, exp_cpu(k0));
      chk(p0 == exp_per(k0), "R3/R4/R5 u0 per_clk", p0, exp_per(k0));
      chk(c1 == exp_cpu(k1), "R2/R4/R5 u1 cpu_clk", c1, exp_cpu(k1));
      chk(p1 == exp_per(k1), "R3 u1 per_clk", p1, exp_per(k1));
      chk(c2 == exp_cpu(k2), "R6 u2 cpu_clk", c2, exp_cpu(k2));
      chk(p2 == exp_per(k2), "R6 u2 per_clk", p2, exp_per(k2));
      chk(s0 == exp_src && s2 == exp_src, "R7 src_is_ext", s0, exp_src);
    end
    if (same_en)
      chk(c0 == c1 && p0 == p1, "R8 instances in step", {c0, p0}, {c1, p1});
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cyc(4);
    cmp_en = 1;
    // R1 reset state
    chk(c0 && p0 && !s0, "R1 reset state", {c0, p0, s0}, 3'b110);
    @(negedge clk);
    rst_n = 1; sync_b = 1;
    @(negedge clk);
    // R5 first edge after release
    chk(!c0 && !p0, "R5 first edge after release", {c0, p0}, 2'b00);
    chk(c1 && p1, "R4 held instance high", {c1, p1}, 2'b11);
    cyc(6);
    sync_b = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i % 5 == 2) sel = ~sel;
    end
    begin
      int hc = 0, hp = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        hc += c0; hp += p0;
        if (i == 14) sel = ~sel;
      end
      // R2 duty over ten periods, R3 over five
      chk(hc == 10, "R2 cpu_clk high count", hc, 10);
      chk(hp == 15, "R3 per_clk high count", hp, 15);
    end
    sync_a = 1; sync_b = 1;
    cyc(3);
    // R4 hold forces both high
    chk(c0 && p0 && c1 && p1, "R4 hold level", {c0, p0, c1, p1}, 4'b1111);
    sync_a = 0; sync_b = 0; same_en = 1;
    cyc(40);
    same_en = 0;
    sync_a = 1;
    @(negedge clk);
    sync_a = 0;
    cyc(20);
    rst_n = 0;
    cyc(2);
    // R1 mid-run reset
    chk(c0 && p0 && !s0 && c2 && p2, "R1 mid-run reset", {c0, p0, s0}, 3'b110);
    rst_n = 1;
    cyc(12);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule